// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This block follows a vector loop whose elements execute one after another in index order and works out the vector length (VL) that remains valid when the loop ends early. A `start_i` pulse latches the loop's VL and its configuration. The loop then presents one element outcome per cycle on `elem_valid_i`. Each outcome carries the element index, a would-fault flag and a 4-bit condition field. A registered verdict for that element appears in the following cycle. Executing the operations and the memory accesses is left to the surrounding pipeline.

Two truncation policies are supported. In memory mode (`mode_i = 0`), a faulting first element raises an exception in the ordinary way. A fault on any later element cuts VL back so that it ends just before that element, so memory mode can never return a length of zero. In condition mode (`mode_i = 1`), one chosen bit of each element's condition field is compared with an invert flag. A match ends the loop. The length then either keeps the failing element (inclusive) or stops just before it (exclusive), so this mode can return zero. After the loop has halted, further element strobes have no effect until the next start.

The control is a three-state machine. The states are IDLE (after reset, nothing latched), RUN (elements accepted) and HALT (verdict frozen). The transitions are:
- START: from any state on `start_i` into RUN, or straight into HALT when the latched VL is zero.
- CUT: RUN to HALT on a fault or a failed test.
- FINISH: RUN to HALT on element VL-1.

Top module: `ffvl_trunc`

## Requirements
- R1: In memory mode, a fault on element 0 sets `raise_exc_o` and `stop_o` and leaves `new_vl_o` at the latched VL, with `store_en_o` low.
- R2: In memory mode, a fault on element k ≥ 1 gives `new_vl_o` = k, sets `stop_o`, keeps `raise_exc_o` low and drives `store_en_o` low.
- R3: In memory mode, `new_vl_o` is never zero while `stop_o` is high.
- R4: In condition mode, the tested bit is `elem_cr_i[bit_sel_i]`, with bit 0 = SO, 1 = EQ, 2 = GT and 3 = LT. The element fails when that bit equals `invert_i`, which sets `stop_o`.
- R5: When an inclusive failure occurs at element k (`incl_i` = 1 and `rec_i` = 0), `new_vl_o` = k+1 and the failing element's `store_en_o` is high unless RC1 is set.
- R6: When an exclusive failure occurs at element k, `new_vl_o` = k and that element's `store_en_o` is low. A failure at element 0 therefore gives 0.
- R7: In condition mode with `rc1_i` set, `store_en_o` stays low for every element.
- R8: In condition mode, only a failed test reduces VL. Passing elements keep `stop_o` low and `new_vl_o` at the latched VL, and `new_vl_o` never exceeds the latched VL.
- R9: `incl_i` is ignored while `rec_i` is 1, so such a failure behaves as exclusive.
- R10: If no element ends the loop early, `done_o` pulses for one cycle in the cycle after element VL-1, with `stop_o` low and `new_vl_o` equal to VL. Each passing element's `store_en_o` is high (outside RC1).
- R11: After the loop halts, element strobes change no output until the next `start_i`. A new start clears `stop_o` and reloads `new_vl_o` with the new VL.
- R12: A start with VL = 0 pulses `done_o` in the following cycle, with `new_vl_o` = 0 and `stop_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a loop and latch VL and configuration |
| vl_i | input | VLW | Loop length |
| mode_i | input | 1 | 0 = memory fault mode, 1 = condition mode |
| bit_sel_i | input | 2 | Tested condition bit (0 SO, 1 EQ, 2 GT, 3 LT) |
| invert_i | input | 1 | Failure value of the tested bit |
| incl_i | input | 1 | Keep the failing element in the length |
| rc1_i | input | 1 | Suppress result stores, keep condition fields only |
| rec_i | input | 1 | Record bit; when 1, disables inclusive mode |
| elem_valid_i | input | 1 | Element outcome present |
| elem_idx_i | input | IDXW | Element index |
| elem_fault_i | input | 1 | Element would fault |
| elem_cr_i | input | 4 | Element condition field |
| stop_o | output | 1 | Loop was ended early |
| new_vl_o | output | VLW | Resulting vector length |
| store_en_o | output | 1 | Result of the last presented element may be committed |
| raise_exc_o | output | 1 | Exception raised on first element |
| done_o | output | 1 | One-cycle pulse when the loop halts |

## Verification
Two functions can land in the same cycle: truncation and normal completion. This happens when the failing element is also element VL-1. The bench sends an inclusive failure on the last index and expects `done_o`, `stop_o` and `new_vl_o` = VL together in the one following cycle. The bench also sends an element-0 fault in memory mode, where the exception, the stop and the done pulse must all rise at the same edge while the length stays at VL.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } ffvl_state_e;

    typedef enum logic {
        MODE_MEM  = 1'b0,
        MODE_COND = 1'b1
    } ffvl_mode_e;

    typedef struct packed {
        ffvl_mode_e mode;
        logic [1:0] bit_sel;
        logic       invert;
        logic       incl;
        logic       rc1;
        logic       rec;
    } ffvl_cfg_t;
endpackage

// File: rtl/ffvl_cond_test.sv
module ffvl_cond_test #(
    parameter int CRW  = 4,
    parameter int SELW = $clog2(CRW)
) (
    input  logic [CRW-1:0]  cr_i,
    input  logic [SELW-1:0] sel_i,
    input  logic            invert_i,
    output logic            fail_o
);
    logic [CRW-1:0] hit;

    // one comparator per condition bit, then a one-hot pick
    for (genvar b = 0; b < CRW; b++) begin : g_bit
        assign hit[b] = (cr_i[b] == invert_i) && (sel_i == SELW'(b));
    end

    assign fail_o = |hit;
endmodule

// File: rtl/ffvl_verdict.sv
module ffvl_verdict
    import ffvl_pkg::*;
#(
    parameter int IDXW = 6,
    parameter int VLW  = 7
) (
    input  ffvl_cfg_t       cfg_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic            fault_i,
    input  logic            cond_fail_i,
    output logic            exc_o,
    output logic            cut_o,
    output logic            keep_o,
    output logic [VLW-1:0]  len_o
);
    logic           incl_eff;
    logic [VLW-1:0] idx_ext;
    logic           first;

    assign incl_eff = cfg_i.incl & ~cfg_i.rec;
    assign idx_ext  = VLW'(idx_i);
    assign first    = (idx_i == '0);

    always_comb begin
        exc_o  = 1'b0;
        cut_o  = 1'b0;
        keep_o = 1'b0;
        len_o  = idx_ext;
        unique case (cfg_i.mode)
            MODE_MEM: begin
                exc_o  = fault_i & first;
                cut_o  = fault_i & ~first;
                keep_o = ~fault_i;
                len_o  = idx_ext;
            end
            MODE_COND: begin
                cut_o  = cond_fail_i;
                keep_o = ~cfg_i.rc1 & (~cond_fail_i | incl_eff);
                len_o  = incl_eff ? idx_ext + VLW'(1) : idx_ext;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ffvl_trunc.sv
module ffvl_trunc
    import ffvl_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VLW    = $clog2(MAX_VL + 1),
    parameter int IDXW   = $clog2(MAX_VL),
    parameter int CRW    = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [VLW-1:0]  vl_i,
    input  logic            mode_i,
    input  logic [1:0]      bit_sel_i,
    input  logic            invert_i,
    input  logic            incl_i,
    input  logic            rc1_i,
    input  logic            rec_i,
    input  logic            elem_valid_i,
    input  logic [IDXW-1:0] elem_idx_i,
    input  logic            elem_fault_i,
    input  logic [CRW-1:0]  elem_cr_i,
    output logic            stop_o,
    output logic [VLW-1:0]  new_vl_o,
    output logic            store_en_o,
    output logic            raise_exc_o,
    output logic            done_o
);
    ffvl_state_e    state_q, state_d;
    ffvl_cfg_t      cfg_q, cfg_in;
    logic [VLW-1:0] vl_q;
    logic           cond_fail, v_exc, v_cut, v_keep, last_elem, accept;
    logic [VLW-1:0] v_len;

    assign cfg_in = '{mode: ffvl_mode_e'(mode_i), bit_sel: bit_sel_i,
                      invert: invert_i, incl: incl_i, rc1: rc1_i, rec: rec_i};

    ffvl_cond_test #(.CRW(CRW), .SELW(2)) cond_i (
        .cr_i     (elem_cr_i),
        .sel_i    (cfg_q.bit_sel),
        .invert_i (cfg_q.invert),
        .fail_o   (cond_fail)
    );

    ffvl_verdict #(.IDXW(IDXW), .VLW(VLW)) verdict_i (
        .cfg_i       (cfg_q),
        .idx_i       (elem_idx_i),
        .fault_i     (elem_fault_i),
        .cond_fail_i (cond_fail),
        .exc_o       (v_exc),
        .cut_o       (v_cut),
        .keep_o      (v_keep),
        .len_o       (v_len)
    );

    assign last_elem = (VLW'(elem_idx_i) == vl_q - VLW'(1));
    assign accept    = (state_q == ST_RUN) && elem_valid_i && !start_i;

    // next-state logic: START, CUT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HALT: begin
                if (start_i) state_d = (vl_i == '0) ? ST_HALT : ST_RUN;
            end
            ST_RUN: begin
                if (start_i)                                state_d = (vl_i == '0) ? ST_HALT : ST_RUN;
                else if (accept && (v_exc || v_cut || last_elem)) state_d = ST_HALT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // registered outputs and latched loop context
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q       <= '0;
            vl_q        <= '0;
            stop_o      <= 1'b0;
            new_vl_o    <= '0;
            store_en_o  <= 1'b0;
            raise_exc_o <= 1'b0;
            done_o      <= 1'b0;
        end else if (start_i) begin
            cfg_q       <= cfg_in;
            vl_q        <= vl_i;
            stop_o      <= 1'b0;
            new_vl_o    <= vl_i;
            store_en_o  <= 1'b0;
            raise_exc_o <= 1'b0;
            done_o      <= (vl_i == '0);
        end else if (accept) begin
            store_en_o <= v_keep;
            if (v_exc) begin
                raise_exc_o <= 1'b1;
                stop_o      <= 1'b1;
                done_o      <= 1'b1;
            end else if (v_cut) begin
                stop_o   <= 1'b1;
                new_vl_o <= v_len;
                done_o   <= 1'b1;
            end else begin
                done_o <= last_elem;
            end
        end else begin
            store_en_o <= 1'b0;
            done_o     <= 1'b0;
        end
    end
endmodule

// File: rtl/ffvl_checker.sv
module ffvl_checker #(
    parameter int VLW = 7
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           start_i,
    input logic           cond_mode_i,
    input logic           rc1_i,
    input logic           halted_i,
    input logic [VLW-1:0] cfg_vl_i,
    input logic           stop_o,
    input logic [VLW-1:0] new_vl_o,
    input logic           store_en_o,
    input logic           raise_exc_o,
    input logic           done_o
);
    AST_EXC_KEEPS_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raise_exc_o |-> (stop_o && new_vl_o == cfg_vl_i)); // R1

    AST_MEM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_o && !cond_mode_i) |-> (new_vl_o != '0)); // R3

    AST_RC1_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_mode_i && rc1_i) |-> !store_en_o); // R7

    AST_VL_NOT_GROWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_vl_o <= cfg_vl_i); // R8

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> !done_o); // R10

    AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halted_i && !start_i) |=> ($stable(new_vl_o) && $stable(stop_o) && $stable(raise_exc_o))); // R11
endmodule

bind ffvl_trunc ffvl_checker #(.VLW(VLW)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cond_mode_i (cfg_q.mode == ffvl_pkg::MODE_COND),
    .rc1_i       (cfg_q.rc1),
    .halted_i    (state_q == ffvl_pkg::ST_HALT),
    .cfg_vl_i    (vl_q),
    .stop_o      (stop_o),
    .new_vl_o    (new_vl_o),
    .store_en_o  (store_en_o),
    .raise_exc_o (raise_exc_o),
    .done_o      (done_o)
);

// File: tb/ffvl_trunc_tb_top.sv
module ffvl_trunc_tb_top;
    localparam int MAX_VL = 64;
    localparam int VLW    = $clog2(MAX_VL + 1);
    localparam int IDXW   = $clog2(MAX_VL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [VLW-1:0]  vl = '0;
    logic            mode = 1'b0;
    logic [1:0]      sel = '0;
    logic            inv = 1'b0, incl = 1'b0, rc1 = 1'b0, rec = 1'b0;
    logic            ev = 1'b0;
    logic [IDXW-1:0] eidx = '0;
    logic            efault = 1'b0;
    logic [3:0]      ecr = '0;
    logic            stop, store_en, exc, done;
    logic [VLW-1:0]  new_vl;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ffvl_trunc #(.MAX_VL(MAX_VL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .mode_i(mode),
        .bit_sel_i(sel), .invert_i(inv), .incl_i(incl), .rc1_i(rc1), .rec_i(rec),
        .elem_valid_i(ev), .elem_idx_i(eidx), .elem_fault_i(efault), .elem_cr_i(ecr),
        .stop_o(stop), .new_vl_o(new_vl), .store_en_o(store_en),
        .raise_exc_o(exc), .done_o(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with outputs settled
    task automatic begin_loop(input logic m, input logic [1:0] s, input logic iv,
                              input logic in, input logic r1, input logic rc, input int len);
        start = 1'b1; vl = VLW'(len); mode = m; sel = s; inv = iv;
        incl = in; rc1 = r1; rec = rc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic elem(input int idx, input logic f, input logic [3:0] cr);
        ev = 1'b1; eidx = IDXW'(idx); efault = f; ecr = cr;
        @(negedge clk);
        ev = 1'b0; efault = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset stop", int'(stop), 0);
        chk("R11 reset new_vl", int'(new_vl), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R1 reset exc", int'(exc), 0);
    endtask

    task automatic t_mem_clean();
        begin_loop(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4);
        for (int i = 0; i < 4; i++) begin
            elem(i, 1'b0, 4'h0);
            chk("R10 store per element", int'(store_en), 1);
            chk("R10 done timing", int'(done), (i == 3) ? 1 : 0);
        end
        chk("R10 full length", int'(new_vl), 4);
        chk("R10 no stop", int'(stop), 0);
        @(negedge clk);
        chk("R10 done one cycle", int'(done), 0);
    endtask

    task automatic t_mem_first_fault();
        begin_loop(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5);
        elem(0, 1'b1, 4'h0);
        chk("R1 exception", int'(exc), 1);
        chk("R1 stop", int'(stop), 1);
        chk("R1 R3 length kept", int'(new_vl), 5);
        chk("R1 no store", int'(store_en), 0);
        chk("R1 done", int'(done), 1);
    endtask

    task automatic t_mem_late_fault();
        begin_loop(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6);
        elem(0, 1'b0, 4'h0);
        elem(1, 1'b0, 4'h0);
        elem(2, 1'b1, 4'h0);
        chk("R2 length", int'(new_vl), 2);
        chk("R2 stop", int'(stop), 1);
        chk("R2 no exception", int'(exc), 0);
        chk("R2 no store", int'(store_en), 0);
        elem(3, 1'b1, 4'h0);
        chk("R11 ignored length", int'(new_vl), 2);
        chk("R11 ignored store", int'(store_en), 0);
        chk("R11 ignored done", int'(done), 0);
        chk("R11 ignored exc", int'(exc), 0);
        begin_loop(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7);
        chk("R11 restart stop cleared", int'(stop), 0);
        chk("R11 restart length", int'(new_vl), 7);
    endtask

    task automatic t_cond_excl();
        // bit 1 = EQ, fails when EQ == 0
        begin_loop(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5);
        elem(0, 1'b0, 4'b0010);
        chk("R8 pass no stop", int'(stop), 0);
        chk("R8 pass length", int'(new_vl), 5);
        chk("R4 pass stored", int'(store_en), 1);
        elem(1, 1'b0, 4'b1101);
        chk("R4 R6 stop", int'(stop), 1);
        chk("R6 exclusive length", int'(new_vl), 1);
        chk("R6 no store", int'(store_en), 0);
    endtask

    task automatic t_cond_zero();
        begin_loop(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4);
        elem(0, 1'b0, 4'b0001);
        chk("R6 zero length", int'(new_vl), 0);
        chk("R6 zero stop", int'(stop), 1);
    endtask

    task automatic t_cond_incl();
        // bit 3 = LT, fails when LT == 1
        begin_loop(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8);
        elem(0, 1'b0, 4'b0100);
        elem(1, 1'b1, 4'b0010);
        chk("R8 fault ignored in cond mode", int'(stop), 0);
        elem(2, 1'b0, 4'b1000);
        chk("R5 inclusive length", int'(new_vl), 3);
        chk("R5 inclusive store", int'(store_en), 1);
        chk("R4 LT stop", int'(stop), 1);
    endtask

    task automatic t_cond_incl_rec();
        begin_loop(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8);
        elem(0, 1'b0, 4'b0000);
        elem(1, 1'b0, 4'b0000);
        elem(2, 1'b0, 4'b1000);
        chk("R9 inclusive disabled length", int'(new_vl), 2);
        chk("R9 inclusive disabled store", int'(store_en), 0);
    endtask

    task automatic t_rc1();
        begin_loop(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3);
        for (int i = 0; i < 3; i++) begin
            elem(i, 1'b0, 4'b0000);
            chk("R7 no store", int'(store_en), 0);
        end
        chk("R10 rc1 done", int'(done), 1);
        chk("R10 rc1 length", int'(new_vl), 3);
        chk("R8 rc1 no stop", int'(stop), 0);
    endtask

    task automatic t_last_fail();
        begin_loop(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4);
        for (int i = 0; i < 3; i++) elem(i, 1'b0, 4'b0000);
        elem(3, 1'b0, 4'b0100);
        chk("R5 last fail done", int'(done), 1);
        chk("R5 last fail stop", int'(stop), 1);
        chk("R5 last fail length", int'(new_vl), 4);
    endtask

    task automatic t_zero_vl();
        begin_loop(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk("R12 done", int'(done), 1);
        chk("R12 length", int'(new_vl), 0);
        chk("R12 no stop", int'(stop), 0);
        elem(0, 1'b1, 4'h0);
        chk("R12 R11 element ignored", int'(exc), 0);
        chk("R12 done dropped", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_clean();
        t_mem_first_fault();
        t_mem_late_fault();
        t_cond_excl();
        t_cond_zero();
        t_cond_incl();
        t_cond_incl_rec();
        t_rc1();
        t_last_fail();
        t_zero_vl();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule